// File: doc/BRIEF.md
# Nibble-Coded Register Command Decoder

This block connects a byte-wide host command stream to a small bank of 8-bit registers. Each command byte holds an opcode in its upper nibble and a 4-bit payload in its lower nibble. The block builds the register address from two nibble commands. It builds each data byte from a low-nibble latch command and a high-nibble commit command. It answers read commands by sending one response byte each on a valid/ready output stream. A read may also step the address forward, which lets the host fetch a run of adjacent registers in a single burst.

The bank holds four kinds of register:
- a fixed identification byte;
- a scratch register that software can use to test the link;
- a mode byte that drives an output port;
- a seven-byte read-only window. The window shows a trigger position and a stop position, each supplied by the capture logic and read least significant byte first, followed by a capture status byte.

The host drives commands on a valid/ready input. A command is taken only when the single response slot can take a new byte.

Top module: `nibble_reg_decoder`

## Requirements
- R1: After reset the address is 0x00, the latched data nibble is 0, the scratch and mode registers are 0x00, `rsp_valid` is 0 and `cmd_ready` is 1.
- R2: Opcode 0x0 replaces address bits 3:0 with the payload. Opcode 0x1 replaces address bits 7:4 with the payload. Neither changes the other half of the address.
- R3: Opcode 0x2 only latches the payload as the pending low nibble and writes nothing. Opcode 0x3 writes {payload, latched nibble} to the register at the current address.
- R4: Successive 0x2/0x3 pairs with no address command in between all write to the same register. The last write wins.
- R5: Opcode 0x4 returns the byte at the current address as exactly one response, one cycle after the command is taken. The address does not change. Responses come out in the order the reads were issued.
- R6: Opcode 0x5 returns the byte at the current address and then adds one to the address, wrapping from 0xFF to 0x00.
- R7: Address 0x00 reads 0xA6. Writes to it have no effect.
- R8: Address 0x01 (scratch) reads back exactly the last byte written to it, for example 0x55 and then 0xAA.
- R9: Addresses 0x08 to 0x0E are read-only. 0x08 to 0x0A hold the trigger position and 0x0B to 0x0D hold the stop position, both least significant byte first. 0x0E holds the status byte. Reads of unmapped addresses return 0x00.
- R10: Opcodes 0x6 to 0xF are accepted and discarded. They change no address, nibble or register and produce no response.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` holds steady and `cmd_ready` is low.
- R12: `mode_o` shows the register at address 0x02. It changes only on a committed write to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command byte present |
| cmd_byte | input | 8 | Opcode in bits 7:4, payload in bits 3:0 |
| cmd_ready | output | 1 | Command taken on this edge when valid |
| rsp_valid | output | 1 | Response byte present |
| rsp_data | output | 8 | Response byte |
| rsp_ready | input | 1 | Consumer takes the response |
| trig_pos | input | POS_W | Trigger position from the capture logic |
| stop_pos | input | POS_W | Stop position from the capture logic |
| cap_status | input | 8 | Capture status byte |
| mode_o | output | 8 | Mode register contents |

## Verification
The hardest case to reach from the ports is a stalled response that overlaps with new reads. A read-with-increment burst must keep its bytes in order even when several commands are waiting behind an unready consumer. A new read can also be taken on the same edge that drains the previous response. The bench reaches these cases by driving `rsp_ready` low for two of every three cycles while it replays the position-window burst and back-to-back plain reads. It also places unknown opcodes between a data-low and its commit, so that a discarded byte that disturbs the latched nibble shows up in the committed value.

// File: rtl/nrd_pkg.sv
// Package for the nibble register decoder.
// Holds the opcode encoding and the decoded-command record that the
// decoder hands to the register bank.
package nrd_pkg;

    // Opcode in bits 7:4 of a command byte.
    typedef enum logic [3:0] {
        OP_ADDR_LO  = 4'h0,
        OP_ADDR_HI  = 4'h1,
        OP_DATA_LO  = 4'h2,
        OP_DATA_WR  = 4'h3,
        OP_READ     = 4'h4,
        OP_READ_INC = 4'h5
    } nrd_op_e;

    // One-hot style action flags plus the payload nibble.
    typedef struct packed {
        logic       set_lo;
        logic       set_hi;
        logic       dat_lo;
        logic       dat_wr;
        logic       rd;
        logic       inc;
        logic [3:0] nib;
    } nrd_cmd_t;

endpackage

// File: rtl/nrd_decode.sv
// Command decoder: turns a raw command byte into action flags.
// Assumes the caller qualifies the flags with its own accept strobe.
// Unknown opcodes produce no flags.
module nrd_decode
    import nrd_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output nrd_cmd_t   cmd
);

    // Decode the opcode nibble into action flags.
    always_comb begin
        cmd     = '0;
        cmd.nib = cmd_byte[3:0];
        case (cmd_byte[7:4])
            OP_ADDR_LO:  cmd.set_lo = 1'b1;
            OP_ADDR_HI:  cmd.set_hi = 1'b1;
            OP_DATA_LO:  cmd.dat_lo = 1'b1;
            OP_DATA_WR:  cmd.dat_wr = 1'b1;
            OP_READ:     cmd.rd     = 1'b1;
            OP_READ_INC: begin
                cmd.rd  = 1'b1;
                cmd.inc = 1'b1;
            end
            default:     ;
        endcase
    end

endmodule

// File: rtl/nrd_regbank.sv
// Register bank: address pointer, pending low nibble, the writable
// registers and the read multiplexer.
// Assumes fire is high only for a command taken this cycle.
// The position window is read-only; writes there are dropped.
module nrd_regbank
    import nrd_pkg::*;
#(
    parameter int         POS_W        = 24,
    parameter logic [7:0] ID_VALUE     = 8'hA6,
    parameter logic [7:0] ID_ADDR      = 8'h00,
    parameter logic [7:0] SCRATCH_ADDR = 8'h01,
    parameter logic [7:0] MODE_ADDR    = 8'h02,
    parameter logic [7:0] POS_BASE     = 8'h08
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  nrd_cmd_t         cmd,
    input  logic [POS_W-1:0] trig_pos,
    input  logic [POS_W-1:0] stop_pos,
    input  logic [7:0]       cap_status,
    output logic [7:0]       addr,
    output logic [7:0]       rd_data,
    output logic [7:0]       mode_q
);

    localparam int POS_BYTES = (POS_W + 7) / 8;
    localparam int WIN_LEN   = 2 * POS_BYTES + 1;

    logic [3:0]             lo_nib;
    logic [7:0]             scratch_q;
    logic [POS_BYTES*8-1:0] trig_ext;
    logic [POS_BYTES*8-1:0] stop_ext;
    logic [7:0]             win [WIN_LEN];
    logic [7:0]             wr_byte;

    assign wr_byte = {cmd.nib, lo_nib};

    // Address pointer: nibble loads and post-read increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (fire) begin
            if (cmd.set_lo) addr[3:0] <= cmd.nib;
            if (cmd.set_hi) addr[7:4] <= cmd.nib;
            if (cmd.inc)    addr      <= addr + 8'd1;
        end
    end

    // Pending low data nibble.
    always_ff @(posedge clk) begin
        if (!rst_n)                  lo_nib <= '0;
        else if (fire && cmd.dat_lo) lo_nib <= cmd.nib;
    end

    // Writable registers, committed by the high-nibble command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scratch_q <= '0;
            mode_q    <= '0;
        end else if (fire && cmd.dat_wr) begin
            if (addr == SCRATCH_ADDR) scratch_q <= wr_byte;
            if (addr == MODE_ADDR)    mode_q    <= wr_byte;
        end
    end

    // Zero-extend the positions to whole bytes.
    always_comb begin
        trig_ext              = '0;
        trig_ext[POS_W-1:0]   = trig_pos;
        stop_ext              = '0;
        stop_ext[POS_W-1:0]   = stop_pos;
    end

    // Position window layout: trigger bytes, stop bytes, status.
    for (genvar g = 0; g < POS_BYTES; g++) begin : g_win
        assign win[g]             = trig_ext[8*g +: 8];
        assign win[POS_BYTES + g] = stop_ext[8*g +: 8];
    end
    assign win[WIN_LEN-1] = cap_status;

    // Read multiplexer for the current address.
    always_comb begin
        rd_data = '0;
        if (addr == ID_ADDR)           rd_data = ID_VALUE;
        else if (addr == SCRATCH_ADDR) rd_data = scratch_q;
        else if (addr == MODE_ADDR)    rd_data = mode_q;
        else begin
            for (int i = 0; i < WIN_LEN; i++) begin
                if (addr == 8'(int'(POS_BASE) + i)) rd_data = win[i];
            end
        end
    end

endmodule

// File: rtl/nrd_rsp.sv
// Response slot: a one-entry output register on a valid/ready stream.
// Assumes rd_fire is raised only when cmd_ready was high.
// Command intake is held off while the slot is full and not draining.
module nrd_rsp (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_fire,
    input  logic [7:0] rd_data,
    input  logic       rsp_ready,
    output logic       rsp_valid,
    output logic [7:0] rsp_data,
    output logic       cmd_ready
);

    assign cmd_ready = !rsp_valid || rsp_ready;

    // Slot occupancy: fill on a read, empty when drained.
    always_ff @(posedge clk) begin
        if (!rst_n)         rsp_valid <= 1'b0;
        else if (rd_fire)   rsp_valid <= 1'b1;
        else if (rsp_ready) rsp_valid <= 1'b0;
    end

    // Slot contents: capture the addressed byte on a read.
    always_ff @(posedge clk) begin
        if (!rst_n)       rsp_data <= '0;
        else if (rd_fire) rsp_data <= rd_data;
    end

endmodule

// File: rtl/nibble_reg_decoder.sv
// Top level: nibble-coded command stream to register bank.
// Connects the decoder, the register bank and the response slot.
// A command is taken when cmd_valid and cmd_ready are both high.
module nibble_reg_decoder
    import nrd_pkg::*;
#(
    parameter int         POS_W        = 24,
    parameter logic [7:0] ID_VALUE     = 8'hA6,
    parameter logic [7:0] ID_ADDR      = 8'h00,
    parameter logic [7:0] SCRATCH_ADDR = 8'h01,
    parameter logic [7:0] MODE_ADDR    = 8'h02,
    parameter logic [7:0] POS_BASE     = 8'h08
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_byte,
    output logic             cmd_ready,
    output logic             rsp_valid,
    output logic [7:0]       rsp_data,
    input  logic             rsp_ready,
    input  logic [POS_W-1:0] trig_pos,
    input  logic [POS_W-1:0] stop_pos,
    input  logic [7:0]       cap_status,
    output logic [7:0]       mode_o
);

    nrd_cmd_t   cmd;
    logic       fire;
    logic [7:0] addr_q;
    logic [7:0] rd_data;

    assign fire = cmd_valid && cmd_ready;

    nrd_decode u_dec (
        .cmd_byte (cmd_byte),
        .cmd      (cmd)
    );

    nrd_regbank #(
        .POS_W        (POS_W),
        .ID_VALUE     (ID_VALUE),
        .ID_ADDR      (ID_ADDR),
        .SCRATCH_ADDR (SCRATCH_ADDR),
        .MODE_ADDR    (MODE_ADDR),
        .POS_BASE     (POS_BASE)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .cmd        (cmd),
        .trig_pos   (trig_pos),
        .stop_pos   (stop_pos),
        .cap_status (cap_status),
        .addr       (addr_q),
        .rd_data    (rd_data),
        .mode_q     (mode_o)
    );

    nrd_rsp u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_fire   (fire && cmd.rd),
        .rd_data   (rd_data),
        .rsp_ready (rsp_ready),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .cmd_ready (cmd_ready)
    );

endmodule

// File: rtl/nrd_checker.sv
// Property checker for nibble_reg_decoder, attached with bind.
// Watches the stream handshakes, the address pointer and the mode output.
module nrd_checker #(
    parameter logic [7:0] ID_ADDR  = 8'h00,
    parameter logic [7:0] ID_VALUE = 8'hA6
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [7:0] cmd_byte,
    input logic       cmd_ready,
    input logic       rsp_valid,
    input logic [7:0] rsp_data,
    input logic       rsp_ready,
    input logic [7:0] mode_o,
    input logic [7:0] addr
);

    logic take;
    logic is_rd;
    assign take  = cmd_valid && cmd_ready;
    assign is_rd = (cmd_byte[7:4] == 4'h4) || (cmd_byte[7:4] == 4'h5);

    a_r11_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

    a_r11_stall_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |-> !cmd_ready);

    a_r5_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
        take && is_rd |=> rsp_valid);

    a_r5_plain_read_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
        take && cmd_byte[7:4] == 4'h4 |=> $stable(addr));

    a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        take && !is_rd && (!rsp_valid || rsp_ready) |=> !rsp_valid);

    a_r10_unknown_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
        take && cmd_byte[7:4] >= 4'h6 |=> $stable(addr));

    a_r6_post_inc: assert property (@(posedge clk) disable iff (!rst_n)
        take && cmd_byte[7:4] == 4'h5 |=> addr == $past(addr) + 8'd1);

    a_r2_addr_lo: assert property (@(posedge clk) disable iff (!rst_n)
        take && cmd_byte[7:4] == 4'h0 |=>
            addr[3:0] == $past(cmd_byte[3:0]) && $stable(addr[7:4]));

    a_r7_id_value: assert property (@(posedge clk) disable iff (!rst_n)
        take && is_rd && addr == ID_ADDR |=> rsp_data == ID_VALUE);

    a_r12_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(take && cmd_byte[7:4] == 4'h3) |=> $stable(mode_o));

endmodule

bind nibble_reg_decoder nrd_checker #(
    .ID_ADDR  (ID_ADDR),
    .ID_VALUE (ID_VALUE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_ready (rsp_ready),
    .mode_o    (mode_o),
    .addr      (addr_q)
);

// File: tb/tb_nibble_reg_decoder.sv
// Bench for nibble_reg_decoder with a behavioural reference model.
// The model keeps the expected responses in a queue and is compared on
// every falling edge. Inputs change 2 ns after a rising edge.
module tb_nibble_reg_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_byte = '0;
    logic        cmd_ready;
    logic        rsp_valid;
    logic [7:0]  rsp_data;
    logic        rsp_ready = 1'b1;
    logic [23:0] trig_pos = '0;
    logic [23:0] stop_pos = '0;
    logic [7:0]  cap_status = '0;
    logic [7:0]  mode_o;

    int    total = 0;
    int    bad = 0;
    bit    stall = 1'b0;
    bit    done = 1'b0;
    int    cyc = 0;
    string cur_tag = "R1";

    // Reference model state.
    int          m_addr = 0;
    int          m_lo = 0;
    int          m_scratch = 0;
    int          m_mode = 0;
    logic [7:0]  exp_q[$];
    string       tag_q[$];

    nibble_reg_decoder dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_byte   (cmd_byte),
        .cmd_ready  (cmd_ready),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .rsp_ready  (rsp_ready),
        .trig_pos   (trig_pos),
        .stop_pos   (stop_pos),
        .cap_status (cap_status),
        .mode_o     (mode_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [7:0] model_read(input int a);
        case (a)
            0:  return 8'hA6;
            1:  return 8'(m_scratch);
            2:  return 8'(m_mode);
            8:  return trig_pos[7:0];
            9:  return trig_pos[15:8];
            10: return trig_pos[23:16];
            11: return stop_pos[7:0];
            12: return stop_pos[15:8];
            13: return stop_pos[23:16];
            14: return cap_status;
            default: return 8'h00;
        endcase
    endfunction

    function automatic void model_apply(input logic [7:0] b);
        int nib;
        nib = int'(b[3:0]);
        case (int'(b[7:4]))
            0: m_addr = (m_addr & 8'hF0) | nib;
            1: m_addr = (m_addr & 8'h0F) | (nib << 4);
            2: m_lo = nib;
            3: begin
                if (m_addr == 1) m_scratch = (nib << 4) | m_lo;
                if (m_addr == 2) m_mode = (nib << 4) | m_lo;
            end
            4: begin
                exp_q.push_back(model_read(m_addr));
                tag_q.push_back(cur_tag);
            end
            5: begin
                exp_q.push_back(model_read(m_addr));
                tag_q.push_back(cur_tag);
                m_addr = (m_addr + 1) & 8'hFF;
            end
            default: ;
        endcase
    endfunction

    // Per-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk(rsp_valid == (exp_q.size() != 0), "R5 response presence", rsp_valid, exp_q.size());
            chk(cmd_ready == (!rsp_valid || rsp_ready), "R11 intake stall", cmd_ready, !rsp_valid || rsp_ready);
            chk(mode_o == 8'(m_mode), "R12 mode output", mode_o, m_mode);
            if (rsp_valid && rsp_ready && exp_q.size() != 0) begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rsp_data == e, t, rsp_data, e);
            end
            if (cmd_valid && cmd_ready) model_apply(cmd_byte);
        end
    end

    // Consumer readiness: always ready, or ready one cycle in three.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            rsp_ready = stall ? (cyc % 3 == 0) : 1'b1;
        end
    end

    task automatic burst(input logic [7:0] q[$]);
        foreach (q[i]) begin
            cmd_valid = 1'b1;
            cmd_byte  = q[i];
            @(negedge clk);
            while (!cmd_ready) @(negedge clk);
            @(posedge clk);
            #2;
        end
        cmd_valid = 1'b0;
    endtask

    task automatic drain();
        int n;
        n = 0;
        while (exp_q.size() != 0 && n < 100) begin
            @(posedge clk);
            #2;
            n++;
        end
        repeat (2) @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #2;
        rst_n = 1'b1;
        // R1: reset state at the ports.
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
        chk(cmd_ready == 1'b1, "R1 cmd_ready after reset", cmd_ready, 1);
        chk(mode_o == 8'h00, "R1 mode after reset", mode_o, 0);
        @(posedge clk);
        #2;
        cur_tag = "R1 address zero reads identification";
        burst('{8'h40});
        cur_tag = "R1 scratch zero after reset";
        burst('{8'h01, 8'h41});
        drain();

        cur_tag = "R8 scratch readback";
        burst('{8'h01, 8'h10, 8'h25, 8'h35, 8'h40, 8'h2A, 8'h3A, 8'h40});
        cur_tag = "R3 data-low alone writes nothing";
        burst('{8'h27, 8'h40});
        cur_tag = "R3 commit uses latched nibble";
        burst('{8'h3C, 8'h40});
        drain();

        cur_tag = "R4 repeated pairs same register";
        burst('{8'h02, 8'h10, 8'h21, 8'h32, 8'h23, 8'h34, 8'h40});
        cur_tag = "R7 identification ignores writes";
        burst('{8'h00, 8'h10, 8'h2F, 8'h3F, 8'h40});
        drain();

        trig_pos = 24'h123456;
        stop_pos = 24'hABCDEF;
        cap_status = 8'h5A;
        cur_tag = "R9 position window burst";
        burst('{8'h08, 8'h10, 8'h50, 8'h50, 8'h50, 8'h50, 8'h50, 8'h50, 8'h50, 8'h40});
        cur_tag = "R9 window ignores writes";
        burst('{8'h08, 8'h10, 8'h21, 8'h32, 8'h40});
        drain();

        cur_tag = "R2 address nibbles";
        burst('{8'h09, 8'h10, 8'h40, 8'h1F, 8'h40, 8'h10, 8'h0E, 8'h40});
        cur_tag = "R6 increment wraps";
        burst('{8'h0F, 8'h1F, 8'h50, 8'h40});
        cur_tag = "R10 unknown opcodes discarded";
        burst('{8'h01, 8'h10, 8'h29, 8'hF7, 8'h6A, 8'h33, 8'h9E, 8'h40, 8'h7C, 8'h41});
        drain();

        stall = 1'b1;
        cur_tag = "R11 stalled window burst";
        burst('{8'h08, 8'h10, 8'h50, 8'h50, 8'h50, 8'h50, 8'h50, 8'h50, 8'h50});
        cur_tag = "R5 stalled plain reads in order";
        burst('{8'h01, 8'h10, 8'h40, 8'h2E, 8'h3D, 8'h40, 8'h40, 8'h00, 8'h40});
        cur_tag = "R12 mode write under stall";
        burst('{8'h02, 8'h10, 8'h29, 8'h36, 8'h40});
        stall = 1'b0;
        drain();

        chk(exp_q.size() == 0, "R5 all reads answered", exp_q.size(), 0);
        finish_run();
    end

endmodule